// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a bus slave for a two-wire serial bus that lets an external master read and write a bank of 8-bit registers. Each register has a 7-bit index. Both bus lines are oversampled by a much faster system clock. They pass through two-flop synchronizers, and then start and stop conditions and clock edges are extracted from them. The slave answers to the 7-bit device address `001110s`, where `s` is a strap pin, so two slaves can share one bus.

After the master addresses the slave for writing, it sends one pointer byte. Bits 6:0 of that byte load the register pointer. Bit 7 chooses whether the pointer advances after every data byte or stays fixed. Data bytes that follow in the same transfer are written through a synchronous register port. A repeated start with the read bit set makes the slave fetch registers through the same port, using a one-cycle read strobe so that read-to-clear registers can react, and shift them out most significant bit first. The master acknowledges each byte it wants followed by another and leaves the last one unacknowledged.

The register port is a plain control interface, not a stream. It has no valid/ready handshake and no back-pressure: a write strobe must be accepted in its own cycle, and read data must be presented exactly one cycle after the read strobe. The bus data line is driven open-drain, through a pull-low enable only.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal `0011100` when the strap is low, or `0011101` when the strap is high, by pulling SDA low during the ninth clock. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R2: When the address does not match, SDA stays released during the acknowledge slot and for all later bytes. No register write or read strobe occurs until the next start condition.
- R3: SDA falling while SCL is high is a start and SDA rising while SCL is high is a stop. A start at any point, including the middle of a byte, restarts address reception. A stop at any point returns the slave to idle with SDA released. Bus clocks seen while idle produce no acknowledge.
- R4: The byte after a write address is the pointer byte. Bits 6:0 load the register pointer, bit 7 set to 1 enables auto-increment, and the pointer byte is acknowledged.
- R5: Each data byte in a write transfer produces exactly one single-cycle `reg_wr_o` pulse carrying the current pointer on `reg_addr_o` and the byte on `reg_wdata_o`, and the byte is acknowledged.
- R6: After a repeated start and a read address, the slave pulses `reg_rd_o` for one cycle with the pointer on `reg_addr_o`. It takes `reg_rdata_i` one cycle later and drives that byte onto SDA most significant bit first. The strobe occurs only while SCL is low.
- R7: A master acknowledge after a read byte causes the next fetch and byte. A master not-acknowledge ends the read, with no further strobe.
- R8: With pointer bit 7 equal to 0, every data byte of a transfer writes, or is read from, the same register, and neighbouring registers are untouched.
- R9: With auto-increment on, the pointer advances by one after each data byte and wraps from 0x7F to 0x00.
- R10: The slave only ever pulls SDA low and never drives it high. It changes its SDA drive only while SCL is low, after SCL has fallen.
- R11: After reset, SDA is released and neither register strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | When high, the pad pulls the data line low |
| addr_strap_i | input | 1 | Selects the least significant bit of the device address |
| reg_addr_o | output | REG_AW (7) | Register pointer presented to the register bank |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid one cycle after `reg_rd_o` |

## Verification
The assertions assume the following about the inputs:
- Each SCL high phase and each SCL low phase lasts longer than the synchronizer latency plus the three-cycle read fetch. This is what allows SDA changes and read strobes to be tied to SCL being low.
- The master never moves SDA and SCL in the same system cycle.
- The register bank returns read data exactly one cycle after the strobe.

The stimulus stays within these limits by building every bus bit from quarter-periods of eight system clocks. SDA moves only a full quarter after each SCL edge. A bench register bank answers with a fixed one-cycle latency.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RD_WAIT,
    ST_RD_LOAD,
    ST_RDATA,
    ST_MACK
  } rs_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;

    // Idle bus lines are high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], line_i[g]};
        last  <= chain[STAGES-1];
      end
    end

    assign level_o[g] = chain[STAGES-1];
    assign rise_o[g]  = chain[STAGES-1] & ~last;
    assign fall_o[g]  = ~chain[STAGES-1] & last;
  end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);

  // The data line may only move while the clock is high when it marks a bus condition.
  assign start_o = scl_lvl_i & sda_fall_i;
  assign stop_o  = scl_lvl_i & sda_rise_i;

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter int          AW     = 7,
  parameter logic [5:0]  DEV_HI = 6'b001110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_pull_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wd_o,
  output logic              reg_rd_o
);

  localparam int DW  = BYTE_W;
  localparam int BCW = $clog2(DW);

  rs_state_t         state;
  logic [BCW-1:0]    bitcnt;
  logic [DW-1:0]     shreg;
  logic              byte_full;
  logic [AW-1:0]     ptr;
  logic              inc;
  logic              rw_q;
  logic              mack_q;
  logic              pull;
  logic              wr_q;
  logic              rd_q;
  logic [DW-1:0]     wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_full <= 1'b0;
      ptr       <= '0;
      inc       <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      pull      <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wd_q      <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (stop_i) begin
        state     <= ST_IDLE;
        pull      <= 1'b0;
        byte_full <= 1'b0;
      end else if (start_i) begin
        state     <= ST_ADDR;
        pull      <= 1'b0;
        bitcnt    <= '0;
        byte_full <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              shreg  <= {shreg[DW-2:0], sda_lvl};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BCW'(DW - 1)) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bitcnt    <= '0;
              if (state == ST_ADDR) begin
                if (shreg[DW-1:1] == {DEV_HI, strap_i}) begin
                  pull  <= 1'b1;
                  rw_q  <= shreg[0];
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                ptr   <= shreg[AW-1:0];
                inc   <= shreg[DW-1];
                pull  <= 1'b1;
                state <= ST_SUB_ACK;
              end else begin
                wr_q  <= 1'b1;
                wd_q  <= shreg;
                pull  <= 1'b1;
                state <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              pull <= 1'b0;
              if (rw_q) begin
                rd_q  <= 1'b1;
                state <= ST_RD_WAIT;
              end else begin
                state <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK: begin
            if (scl_fall) begin
              pull  <= 1'b0;
              state <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              pull  <= 1'b0;
              ptr   <= ptr + AW'(inc);
              state <= ST_WDATA;
            end
          end
          ST_RD_WAIT: begin
            ptr   <= ptr + AW'(inc);
            state <= ST_RD_LOAD;
          end
          ST_RD_LOAD: begin
            shreg  <= rd_data_i;
            pull   <= ~rd_data_i[DW-1];
            bitcnt <= '0;
            state  <= ST_RDATA;
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt == BCW'(DW - 1)) begin
                pull   <= 1'b0;
                bitcnt <= '0;
                state  <= ST_MACK;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[DW-2:0], 1'b0};
                pull   <= ~shreg[DW-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                rd_q  <= 1'b1;
                state <= ST_RD_WAIT;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull;
  assign reg_addr_o = ptr;
  assign reg_wr_o   = wr_q;
  assign reg_wd_o   = wd_q;
  assign reg_rd_o   = rd_q;

  // A start condition always leads straight into address reception.
  assert_start_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state == ST_ADDR));

  // A stop condition leaves the slave idle with the line released.
  assert_stop_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state == ST_IDLE && !sda_pull_o));

  // The slave begins pulling the line low only while the clock is low.
  assert_pull_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_lvl);

  // A write strobe never coincides with a read strobe.
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  // Each received data byte gives a single-cycle write strobe.
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  // Register fetches happen only while the bus clock is low.
  assert_rd_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |-> !scl_lvl);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         REG_AW      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b001110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              addr_strap_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [7:0]        reg_rdata_i
);

  localparam int IDX_SCL = 0;
  localparam int IDX_SDA = 1;

  logic [1:0] lvl, rise, fall;
  logic       start_c, stop_c;

  i2c_line_sync #(
    .LINES  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  ({sda_i, scl_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  i2c_cond_detect u_cond (
    .scl_lvl_i  (lvl[IDX_SCL]),
    .sda_rise_i (rise[IDX_SDA]),
    .sda_fall_i (fall[IDX_SDA]),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_rs_fsm #(
    .AW     (REG_AW),
    .DEV_HI (DEV_ADDR_HI)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (lvl[IDX_SCL]),
    .scl_rise   (rise[IDX_SCL]),
    .scl_fall   (fall[IDX_SCL]),
    .sda_lvl    (lvl[IDX_SDA]),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .strap_i    (addr_strap_i),
    .rd_data_i  (reg_rdata_i),
    .sda_pull_o (sda_pull_o),
    .reg_addr_o (reg_addr_o),
    .reg_wr_o   (reg_wr_o),
    .reg_wd_o   (reg_wdata_o),
    .reg_rd_o   (reg_rd_o)
  );

endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb_top;

  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic strap = 1'b1;
  logic pull;
  wire  sda_line = m_sda & ~pull;

  logic [6:0] raddr;
  logic       rwr, rrd;
  logic [7:0] rwd;
  logic [7:0] rrdata = 8'h00;

  logic [7:0] regmem [128];
  logic [7:0] refmem [128];

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R11";

  typedef struct {
    bit wr;
    int addr;
    int data;
  } acc_t;
  acc_t expq[$];
  acc_t e;
  logic pull_prev = 1'b0;

  i2c_reg_slave dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (m_scl),
    .sda_i        (sda_line),
    .sda_pull_o   (pull),
    .addr_strap_i (strap),
    .reg_addr_o   (raddr),
    .reg_wr_o     (rwr),
    .reg_wdata_o  (rwd),
    .reg_rd_o     (rrd),
    .reg_rdata_i  (rrdata)
  );

  // Bench register bank with a one-cycle read latency.
  always @(posedge clk) begin
    if (rwr) regmem[raddr] <= rwd;
    if (rrd) rrdata <= regmem[raddr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of register strobes against the expected access queue,
  // and of SDA drive changes against the bus clock (R10).
  always @(negedge clk) begin
    if (rst_n) begin
      if (rwr || rrd) begin
        if (expq.size() == 0) begin
          chk(1'b0, cur_req, int'({rwr, raddr, rwd}), -1);
        end else begin
          e = expq.pop_front();
          chk(e.wr == rwr && e.addr == int'(raddr) && (!rwr || e.data == int'(rwd)),
              cur_req, int'({rwr, raddr, rwd}), int'({e.wr, e.addr[6:0], e.data[7:0]}));
        end
      end
      if (pull != pull_prev) chk(!m_scl, "R10", int'(m_scl), 0);
      pull_prev = pull;
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    qwait();
    m_scl = 1'b1; qwait();
    qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    b = sda_line; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic read_byte(output logic [7:0] d, input bit more);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!more);
  endtask

  function automatic logic [7:0] dev_byte(input bit rd);
    return {6'b001110, strap, rd};
  endfunction

  task automatic wr_txn(input logic [7:0] sub, input int n, input logic [23:0] dv, input string req);
    bit ack;
    int p = int'(sub[6:0]);
    cur_req = req;
    for (int k = 0; k < n; k++) begin
      expq.push_back('{1'b1, p, int'(dv[8*k +: 8])});
      refmem[p] = dv[8*k +: 8];
      if (sub[7]) p = (p + 1) % 128;
    end
    bus_start();
    write_byte(dev_byte(1'b0), ack); chk(ack, "R1", int'(ack), 1);
    write_byte(sub, ack);            chk(ack, "R4", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      write_byte(dv[8*k +: 8], ack);
      chk(ack, req, int'(ack), 1);
    end
    bus_stop();
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic rd_txn(input logic [7:0] sub, input int n, input string req);
    bit ack;
    logic [7:0] v;
    int p = int'(sub[6:0]);
    int q;
    cur_req = req;
    bus_start();
    write_byte(dev_byte(1'b0), ack); chk(ack, "R1", int'(ack), 1);
    write_byte(sub, ack);            chk(ack, "R4", int'(ack), 1);
    q = p;
    for (int k = 0; k < n; k++) begin
      expq.push_back('{1'b0, q, 0});
      if (sub[7]) q = (q + 1) % 128;
    end
    bus_start();
    write_byte(dev_byte(1'b1), ack); chk(ack, "R6", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      read_byte(v, k < n - 1);
      chk(v == refmem[p], req, int'(v), int'(refmem[p]));
      if (sub[7]) p = (p + 1) % 128;
    end
    bus_stop();
    // R7: the not-acknowledged byte is the last fetch
    chk(expq.size() == 0, "R7", expq.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit ack;
    for (int i = 0; i < 128; i++) begin
      regmem[i] = 8'((i * 7 + 3) & 255);
      refmem[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!pull, "R11", int'(pull), 0);
    chk(!rwr && !rrd, "R11", int'({rwr, rrd}), 0);

    wr_txn(8'h05, 1, 24'h00005C, "R5");
    rd_txn(8'h05, 1, "R6");
    wr_txn(8'h90, 3, 24'h332211, "R4");
    rd_txn(8'h90, 3, "R7");
    wr_txn(8'h20, 2, 24'h0055AA, "R8");
    rd_txn(8'h20, 2, "R8");
    rd_txn(8'h21, 1, "R8");
    wr_txn(8'hFF, 2, 24'h00E2E1, "R9");
    rd_txn(8'hFF, 2, "R9");

    // R2: wrong address is ignored for the whole transfer
    cur_req = "R2";
    bus_start();
    write_byte(8'h38, ack); chk(!ack, "R2", int'(ack), 0);
    write_byte(8'h05, ack); chk(!ack, "R2", int'(ack), 0);
    write_byte(8'h77, ack); chk(!ack, "R2", int'(ack), 0);
    bus_stop();
    rd_txn(8'h05, 1, "R2");

    // R3: clocks while idle get no acknowledge
    cur_req = "R3";
    write_byte(8'h3A, ack); chk(!ack, "R3", int'(ack), 0);
    m_scl = 1'b1; qwait();
    // R3: start in the middle of a byte restarts address reception
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    wr_txn(8'h40, 1, 24'h000096, "R3");
    // R3: stop in the middle of a byte returns to idle
    bus_start();
    write_byte(dev_byte(1'b0), ack); chk(ack, "R3", int'(ack), 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    cur_req = "R3";
    write_byte(8'h3A, ack); chk(!ack, "R3", int'(ack), 0);
    m_scl = 1'b1; qwait();
    rd_txn(8'h40, 1, "R3");

    // R1: strap low selects the other address
    strap = 1'b0;
    qwait();
    wr_txn(8'h30, 1, 24'h00003C, "R1");
    rd_txn(8'h30, 1, "R1");
    cur_req = "R1";
    bus_start();
    write_byte(8'h3A, ack); chk(!ack, "R1", int'(ack), 0);
    bus_stop();

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R2", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule